// File: doc/BRIEF.md
# Gate Window Frame Admission Check

This block sits between a time-aware gate schedule and the transmit selection logic of an Ethernet port. For every traffic class it decides, each clock cycle, whether the frame now waiting at the head of that class's queue may begin transmission. A class is admitted only when its gate is open and the frame is certain to leave the wire before the gate closes.

The schedule sequencer supplies the gate states of the entry in force and of the entry that follows it, the nanoseconds left in the entry in force, and the length of the following entry. The block subtracts a programmable buffer-to-line delay from the remaining time. It then works out how long each head frame occupies the line, counting the inter-frame gap and preamble, and at 100 Mbps an additional rounding margin. The check looks only one entry ahead: it adds the following interval to the window only when that class's gate stays open across the entry boundary. The resulting eligibility vector is registered and goes to the selection logic.

Top module: `gate_admit`

## Requirements
- R1: While `rstN` is low, and on the first rising edge after it, `eligible` is all zero.
- R2: A class whose `curGate` bit is 0 is reported not eligible, whatever its frame length and the timing inputs.
- R3: With `speedSlow` = 0 (1 Gbps), the line occupancy of a frame is (length + 20) bytes at 8 ns per byte.
- R4: With `speedSlow` = 1 (100 Mbps), the line occupancy is (length + 20 + ceil(length/256)) bytes at 80 ns per byte. For example, a 1000-byte frame needs 1024 byte times, or 81920 ns.
- R5: The effective remaining time is `remainNs` minus `delayComp`, and is held at zero when `delayComp` is equal to or larger than `remainNs`.
- R6: `nextNs` is added to the window of a class only when both its `curGate` and `nextGate` bits are 1. Otherwise the window is the effective remaining time alone.
- R7: An open class is eligible exactly when its window is greater than or equal to the required time, so an exact fit is admitted and a window 1 ns shorter is not.
- R8: `eligible` is registered. It reflects the inputs sampled at the previous rising clock edge, and each class i uses only bit i of the gate vectors and bits [i*LEN_W +: LEN_W] of `frameLen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curGate | input | NUM_TC | Gate state of the entry in force, 1 = open |
| nextGate | input | NUM_TC | Gate state of the following entry, 1 = open |
| remainNs | input | TI_W | Nanoseconds left in the entry in force |
| nextNs | input | TI_W | Length of the following entry in ns |
| delayComp | input | DC_W | Buffer-to-line delay compensation in ns |
| frameLen | input | NUM_TC*LEN_W | Head-of-queue frame length in bytes, class i in bits [i*LEN_W +: LEN_W] |
| speedSlow | input | 1 | 1 = 100 Mbps, 0 = 1 Gbps |
| eligible | output | NUM_TC | Registered per-class admission result |

## Verification
Two of the block's functions can settle the same result in the same cycle: the delay subtraction, which can drive the window down to zero, and the one-entry look-ahead, which adds the following interval back when the gate stays open. The bench provokes both together with a delay larger than the remaining time, combined with an open or closed following gate, for classes that sit side by side in one input vector. It also drives random vectors in which some classes chain and others do not. Each class is compared with a bench model at the cycle after the inputs are applied, and exact-fit windows and windows one nanosecond short are directed at both link speeds.

// File: rtl/gate_admit_pkg.sv
package gate_admit_pkg;
  // Per-class strobes from control to datapath
  typedef struct packed {
    logic gateOpen;   // gate in force is open
    logic chainNext;  // following interval extends the window
    logic slowLink;   // 100 Mbps timing applies
  } admitCtrl_t;

  localparam int LINE_OVERHEAD_BYTES = 20;
  localparam int FAST_BYTE_NS        = 8;
  localparam int SLOW_BYTE_NS        = 80;
  localparam int MARGIN_SHIFT        = 8;
endpackage

// File: rtl/gate_admit_ctrl.sv
module gate_admit_ctrl
  import gate_admit_pkg::*;
#(
  parameter int NUM_TC = 8
) (
  input  logic [NUM_TC-1:0]             curGate,
  input  logic [NUM_TC-1:0]             nextGate,
  input  logic                          speedSlow,
  output admitCtrl_t [NUM_TC-1:0]       ctrl
);
  for (genvar i = 0; i < NUM_TC; i++) begin : g_cls
    always_comb begin
      ctrl[i].gateOpen  = curGate[i];
      ctrl[i].chainNext = curGate[i] & nextGate[i];
      ctrl[i].slowLink  = speedSlow;
    end
  end
endmodule

// File: rtl/gate_admit_dp.sv
module gate_admit_dp
  import gate_admit_pkg::*;
#(
  parameter int NUM_TC = 8,
  parameter int LEN_W  = 14,
  parameter int TI_W   = 24,
  parameter int DC_W   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  admitCtrl_t [NUM_TC-1:0]   ctrl,
  input  logic [TI_W-1:0]           remainNs,
  input  logic [TI_W-1:0]           nextNs,
  input  logic [DC_W-1:0]           delayComp,
  input  logic [NUM_TC*LEN_W-1:0]   frameLen,
  output logic [NUM_TC-1:0]         eligible
);
  localparam int BYTE_W = LEN_W + 2;
  localparam int WIN_W  = TI_W + 1;
  localparam int CMP_W  = (WIN_W > BYTE_W + 7) ? WIN_W : BYTE_W + 7;

  logic [TI_W-1:0]  delayExt;
  logic [TI_W-1:0]  effRemain;
  logic [CMP_W-1:0] winSolo;
  logic [CMP_W-1:0] winChain;
  logic [NUM_TC-1:0] fitVec;

  assign delayExt = TI_W'(delayComp);

  always_comb begin
    if (remainNs > delayExt) effRemain = remainNs - delayExt;
    else                     effRemain = '0;
    winSolo  = CMP_W'(effRemain);
    winChain = CMP_W'(effRemain) + CMP_W'(nextNs);
  end

  for (genvar i = 0; i < NUM_TC; i++) begin : g_cls
    logic [LEN_W-1:0]  lenB;
    logic [BYTE_W-1:0] marginB;
    logic [BYTE_W-1:0] lineB;
    logic [CMP_W-1:0]  needNs;
    logic [CMP_W-1:0]  winNs;

    assign lenB = frameLen[i*LEN_W +: LEN_W];

    always_comb begin
      if (ctrl[i].slowLink)
        marginB = (BYTE_W'(lenB) + BYTE_W'((1 << MARGIN_SHIFT) - 1)) >> MARGIN_SHIFT;
      else
        marginB = '0;
      lineB = BYTE_W'(lenB) + BYTE_W'(LINE_OVERHEAD_BYTES) + marginB;
      if (ctrl[i].slowLink) needNs = CMP_W'(lineB) * CMP_W'(SLOW_BYTE_NS);
      else                  needNs = CMP_W'(lineB) * CMP_W'(FAST_BYTE_NS);
      winNs     = ctrl[i].chainNext ? winChain : winSolo;
      fitVec[i] = ctrl[i].gateOpen && (winNs >= needNs);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) eligible <= '0;
    else       eligible <= fitVec;
  end
endmodule

// File: rtl/gate_admit.sv
module gate_admit
  import gate_admit_pkg::*;
#(
  parameter int NUM_TC = 8,
  parameter int LEN_W  = 14,
  parameter int TI_W   = 24,
  parameter int DC_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_TC-1:0]       curGate,
  input  logic [NUM_TC-1:0]       nextGate,
  input  logic [TI_W-1:0]         remainNs,
  input  logic [TI_W-1:0]         nextNs,
  input  logic [DC_W-1:0]         delayComp,
  input  logic [NUM_TC*LEN_W-1:0] frameLen,
  input  logic                    speedSlow,
  output logic [NUM_TC-1:0]       eligible
);
  admitCtrl_t [NUM_TC-1:0] ctrl;

  gate_admit_ctrl #(.NUM_TC(NUM_TC)) u_ctrl (
    .curGate  (curGate),
    .nextGate (nextGate),
    .speedSlow(speedSlow),
    .ctrl     (ctrl)
  );

  gate_admit_dp #(
    .NUM_TC(NUM_TC), .LEN_W(LEN_W), .TI_W(TI_W), .DC_W(DC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .remainNs (remainNs),
    .nextNs   (nextNs),
    .delayComp(delayComp),
    .frameLen (frameLen),
    .eligible (eligible)
  );
endmodule

// File: rtl/gate_admit_chk.sv
module gate_admit_chk #(
  parameter int NUM_TC = 8,
  parameter int LEN_W  = 14,
  parameter int TI_W   = 24,
  parameter int DC_W   = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_TC-1:0]       curGate,
  input logic [NUM_TC-1:0]       nextGate,
  input logic [TI_W-1:0]         remainNs,
  input logic [TI_W-1:0]         nextNs,
  input logic [DC_W-1:0]         delayComp,
  input logic [NUM_TC*LEN_W-1:0] frameLen,
  input logic                    speedSlow,
  input logic [NUM_TC-1:0]       eligible
);
  // R1: reset clears the vector
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> eligible == '0);

  for (genvar i = 0; i < NUM_TC; i++) begin : g_cls
    logic [63:0] lenQ, remQ, dlyQ;
    assign lenQ = 64'(frameLen[i*LEN_W +: LEN_W]);
    assign remQ = 64'(remainNs);
    assign dlyQ = 64'(delayComp);

    // R2: closed gate never admitted
    p_closed_block_r2: assert property (@(posedge clk) disable iff (!rstN)
      !curGate[i] |=> !eligible[i]);

    // R3 / R7: a solo window that covers the fast-link need admits
    p_fast_fit_r3: assert property (@(posedge clk) disable iff (!rstN)
      (curGate[i] && !nextGate[i] && !speedSlow && remQ >= dlyQ + 8 * (lenQ + 20))
      |=> eligible[i]);

    // R4: a solo window short of the slow need without margin rejects
    p_slow_short_r4: assert property (@(posedge clk) disable iff (!rstN)
      (curGate[i] && !nextGate[i] && speedSlow && remQ < dlyQ + 80 * (lenQ + 20))
      |=> !eligible[i]);

    // R5 / R6: delay eating all remaining time with no chaining rejects
    p_zero_window_r5: assert property (@(posedge clk) disable iff (!rstN)
      (curGate[i] && !nextGate[i] && remQ <= dlyQ) |=> !eligible[i]);
  end
endmodule

bind gate_admit gate_admit_chk #(
  .NUM_TC(NUM_TC), .LEN_W(LEN_W), .TI_W(TI_W), .DC_W(DC_W)
) u_chk (.*);

// File: tb/sim_gate_admit.sv
module sim_gate_admit;
  localparam int NUM_TC = 8;
  localparam int LEN_W  = 14;
  localparam int TI_W   = 24;
  localparam int DC_W   = 16;

  logic                    clk = 1'b0;
  logic                    rstN;
  logic [NUM_TC-1:0]       curGate, nextGate;
  logic [TI_W-1:0]         remainNs, nextNs;
  logic [DC_W-1:0]         delayComp;
  logic [NUM_TC*LEN_W-1:0] frameLen;
  logic                    speedSlow;
  logic [NUM_TC-1:0]       eligible;
  logic [LEN_W-1:0]        lens [NUM_TC];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < NUM_TC; i++) frameLen[i*LEN_W +: LEN_W] = lens[i];

  gate_admit #(.NUM_TC(NUM_TC), .LEN_W(LEN_W), .TI_W(TI_W), .DC_W(DC_W)) u0 (
    .clk(clk), .rstN(rstN), .curGate(curGate), .nextGate(nextGate),
    .remainNs(remainNs), .nextNs(nextNs), .delayComp(delayComp),
    .frameLen(frameLen), .speedSlow(speedSlow), .eligible(eligible)
  );

  function automatic bit modelFit(bit open, bit nxt, longint len, bit slow,
                                  longint rem, longint nx, longint dly);
    longint eff, win, bytesN, need;
    eff    = (rem > dly) ? rem - dly : 0;
    win    = (open && nxt) ? eff + nx : eff;
    bytesN = len + 20 + (slow ? (len + 255) / 256 : 0);
    need   = bytesN * (slow ? 80 : 8);
    return open && (win >= need);
  endfunction

  task automatic checkBit(string tag, int cls, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s class %0d actual %0b expected %0b", tag, cls, act, exp);
    end
  endtask

  // Apply at negedge, result registered at next posedge, sample at following negedge
  task automatic applyCheck(string tag);
    bit expV [NUM_TC];
    for (int i = 0; i < NUM_TC; i++)
      expV[i] = modelFit(curGate[i], nextGate[i], longint'(lens[i]), speedSlow,
                         longint'(remainNs), longint'(nextNs), longint'(delayComp));
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NUM_TC; i++) checkBit(tag, i, eligible[i], expV[i]);
  endtask

  task automatic setAll(bit [NUM_TC-1:0] cg, bit [NUM_TC-1:0] ng, int len, bit slow,
                        int rem, int nx, int dly);
    curGate = cg; nextGate = ng; speedSlow = slow;
    remainNs = TI_W'(rem); nextNs = TI_W'(nx); delayComp = DC_W'(dly);
    for (int i = 0; i < NUM_TC; i++) lens[i] = LEN_W'(len);
  endtask

  initial begin
    rstN = 1'b0;
    setAll('1, '1, 64, 1'b0, 1000000, 1000000, 0);
    repeat (2) @(negedge clk);
    // R1: inputs would admit, reset holds zero
    for (int i = 0; i < NUM_TC; i++) checkBit("R1", i, eligible[i], 1'b0);
    rstN = 1'b1;

    // R2: closed gates with huge windows and tiny frames
    setAll(8'h5A, '1, 1, 1'b0, 16000000, 16000000, 0);
    applyCheck("R2");

    // R3 / R7: 128-byte frame at 1 Gbps needs 148*8 = 1184 ns
    setAll('1, '0, 128, 1'b0, 1184, 50000, 0);
    applyCheck("R3_R7_exact");
    for (int i = 0; i < NUM_TC; i++) checkBit("R3", i, eligible[i], 1'b1);
    setAll('1, '0, 128, 1'b0, 1183, 50000, 0);
    applyCheck("R7_short");
    for (int i = 0; i < NUM_TC; i++) checkBit("R7", i, eligible[i], 1'b0);

    // R4: 1000-byte frame at 100 Mbps needs 1024*80 = 81920 ns
    setAll('1, '0, 1000, 1'b1, 81920, 0, 0);
    applyCheck("R4_exact");
    for (int i = 0; i < NUM_TC; i++) checkBit("R4", i, eligible[i], 1'b1);
    setAll('1, '0, 1000, 1'b1, 81919, 0, 0);
    applyCheck("R4_short");
    for (int i = 0; i < NUM_TC; i++) checkBit("R4", i, eligible[i], 1'b0);

    // R5: delay larger than remaining, no chaining
    setAll('1, '0, 46, 1'b0, 300, 900000, 500);
    applyCheck("R5_sat");
    // R5: delay eats exactly the slack
    setAll('1, '0, 128, 1'b0, 1284, 0, 100);
    applyCheck("R5_exact");
    for (int i = 0; i < NUM_TC; i++) checkBit("R5", i, eligible[i], 1'b1);

    // R6: saturated delay with chaining on half the classes
    setAll('1, 8'h0F, 128, 1'b0, 300, 2000, 500);
    applyCheck("R6_mix");
    for (int i = 0; i < NUM_TC; i++) checkBit("R6", i, eligible[i], i < 4);

    // R8: per-class lengths differ, one-entry window
    setAll('1, '0, 0, 1'b0, 4000, 0, 0);
    for (int i = 0; i < NUM_TC; i++) lens[i] = LEN_W'(400 + i * 20);
    applyCheck("R8_lanes");

    // Random mix
    void'($urandom(32'd7321));
    for (int n = 0; n < 400; n++) begin
      curGate   = NUM_TC'($urandom);
      nextGate  = NUM_TC'($urandom);
      speedSlow = 1'($urandom);
      remainNs  = TI_W'($urandom_range(0, speedSlow ? 400000 : 40000));
      nextNs    = TI_W'($urandom_range(0, speedSlow ? 200000 : 20000));
      delayComp = DC_W'($urandom_range(0, 3000));
      for (int i = 0; i < NUM_TC; i++) lens[i] = LEN_W'($urandom_range(0, 3000));
      applyCheck("R3_R4_R6_R7_rand");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule